// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, for each incoming frame, whether its 48-bit destination address is accepted by the receive path. It holds sixteen perfect-match station addresses. The frame length is checked first, then a fixed order of tests is applied. When a frame is accepted through a catch-all mode, one of two status flags is raised so that the receive path can record why the frame was taken.

The address table is written from a setup frame. The setup frame arrives as a byte stream with first-byte and last-byte markers, and is gathered into a shadow copy of the table. The live table is replaced only when the stream ends on exactly the expected byte count. Lookups are presented as a one-cycle request carrying the address, the frame length and the current mode bits. The answer is registered and appears for one cycle on the next clock.

The setup loader is a three-state machine:
- **IDLE** waits for a first byte. A first byte that is not also a last byte takes transition *start* to **FILL**.
- **FILL** stores address bytes while the count is below the setup size.
  - A last byte that lands exactly on the setup size takes transition *commit* back to IDLE and schedules the table copy.
  - A last byte that lands short takes transition *abandon* back to IDLE.
  - Any byte beyond the setup size takes transition *overrun* to **DRAIN**.
- **DRAIN** ignores bytes until a last byte, which takes transition *flush* to IDLE.
- A first byte seen in any state takes transition *restart*, which begins a new collection at byte zero.

Top module: `dst_addr_filter`

## Requirements
- R1: After reset, `dec_valid`, `dec_accept`, `dec_filter_fail` and `dec_multicast` are all low, and every table entry is marked empty. No lookup matches an empty entry, and this includes the all-zero address.
- R2: A lookup whose address is all ones (48'hFFFF_FFFF_FFFF) and whose length is legal is accepted with both flags low. This holds for every combination of mode bits, inverse filtering included.
- R3: Otherwise, when `mode_promisc` or `mode_rx_all` is high, a legal-length frame is accepted. `dec_filter_fail` is raised and `dec_multicast` is left low.
- R4: Otherwise, when `mode_all_multi` is high and bit 40 of `lookup_addr` is 1, a legal-length frame is accepted and `dec_multicast` is raised. Bit 40 is the least significant bit of address byte 0, and byte 0 occupies bits 47:40.
- R5: Otherwise the decision is a hit against any of the 16 loaded entries, with both flags low.
- R6: `mode_inverse` inverts only the perfect-match result of R5. It has no effect on the accepts of R2, R3 or R4.
- R7: In a setup frame, entry n occupies bytes 12·n to 12·n+11. Slot bytes 0, 1, 4, 5, 8 and 9 become address bytes 0 to 5 of that entry, and the other six slot bytes are ignored.
- R8: The live table is replaced only when a setup frame ends, marked by `setup_last`, on exactly its 192nd byte. A shorter or longer setup frame leaves the table unchanged.
- R9: A lookup with `lookup_len` below 14 or above 2048 is rejected with both flags low, before any of the tests in R2 to R6.
- R10: `dec_valid` is high in exactly the cycle after a cycle with `lookup_valid` high, and the three result outputs are low whenever `dec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_valid | input | 1 | Setup byte present |
| setup_byte | input | 8 | Setup frame byte |
| setup_first | input | 1 | Marks the first byte of a setup frame |
| setup_last | input | 1 | Marks the last byte of a setup frame |
| lookup_valid | input | 1 | Lookup request, one cycle |
| lookup_addr | input | 48 | Destination address; byte 0 in bits 47:40 |
| lookup_len | input | LEN_W (13) | Frame length in bytes |
| mode_promisc | input | 1 | Promiscuous mode |
| mode_rx_all | input | 1 | Receive-all mode |
| mode_all_multi | input | 1 | Pass all multicast frames |
| mode_inverse | input | 1 | Invert the perfect-match result |
| dec_valid | output | 1 | Decision present |
| dec_accept | output | 1 | Frame accepted |
| dec_filter_fail | output | 1 | Accepted by promiscuous or receive-all mode |
| dec_multicast | output | 1 | Accepted by the pass-all-multicast mode |

## Verification
The hardest situation to reach is a setup frame that fails part way. The bench must show that a short or overrunning stream leaves the old table intact, even though the shadow copy has already been overwritten. To get there, the bench loads a known table and then streams 191-byte and 193-byte frames that carry different addresses. After each, it looks up both the old and the new addresses, before finally sending a correct frame that must swap them. Filler bytes with a distinct value fill the unused slot positions, so a wrong offset mapping shows up as a missed match.

// File: rtl/daf_pkg.sv
package daf_pkg;

    typedef logic [47:0] mac_t;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_FILL  = 2'd1,
        LD_DRAIN = 2'd2
    } ld_state_t;

    typedef struct packed {
        logic promisc;
        logic rx_all;
        logic all_multi;
        logic inverse;
    } mode_t;

    // Slot offset -> address byte index; offsets with bit 1 set are filler.
    function automatic logic slot_is_addr(input logic [3:0] off);
        return (off[1] == 1'b0) && (off <= 4'd9);
    endfunction

    function automatic logic [2:0] slot_byte_idx(input logic [3:0] off);
        return {off[3:2], off[0]};
    endfunction

endpackage

// File: rtl/daf_setup_loader.sv
module daf_setup_loader
    import daf_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int SLOT_BYTES  = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [7:0]             in_byte,
    input  logic                   in_first,
    input  logic                   in_last,
    output logic                   commit_o,
    output mac_t [NUM_ENTRIES-1:0] image_o
);

    localparam int SETUP_BYTES = NUM_ENTRIES * SLOT_BYTES;
    localparam int CNT_W       = $clog2(SETUP_BYTES + 1);
    localparam int SLOT_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    ld_state_t              state_q, state_d;
    logic [CNT_W-1:0]       cnt_q;
    logic [SLOT_W-1:0]      slot_q;
    logic [3:0]             off_q;
    mac_t [NUM_ENTRIES-1:0] shadow_q;
    logic                   commit_q;

    logic              start;
    logic              wr_en;
    logic [CNT_W-1:0]  wr_cnt;
    logic [SLOT_W-1:0] wr_slot;
    logic [3:0]        wr_off;
    logic              commit_d;

    assign start   = in_valid && in_first;
    assign wr_cnt  = start ? '0 : cnt_q;
    assign wr_slot = start ? '0 : slot_q;
    assign wr_off  = start ? '0 : off_q;
    assign wr_en   = start ||
                     (state_q == LD_FILL && in_valid &&
                      cnt_q < CNT_W'(SETUP_BYTES));
    assign commit_d = wr_en && in_last &&
                      (wr_cnt == CNT_W'(SETUP_BYTES - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = in_last ? LD_IDLE : LD_FILL;      // restart / start
        end else begin
            unique case (state_q)
                LD_IDLE: state_d = LD_IDLE;
                LD_FILL: begin
                    if (in_valid) begin
                        if (cnt_q >= CNT_W'(SETUP_BYTES))
                            state_d = in_last ? LD_IDLE : LD_DRAIN; // overrun
                        else if (in_last)
                            state_d = LD_IDLE;           // commit / abandon
                    end
                end
                LD_DRAIN: begin
                    if (in_valid && in_last) state_d = LD_IDLE; // flush
                end
                default: state_d = LD_IDLE;
            endcase
        end
    end

    // collection datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            slot_q   <= '0;
            off_q    <= '0;
            shadow_q <= '0;
        end else if (wr_en) begin
            if (slot_is_addr(wr_off))
                shadow_q[wr_slot][8*(5 - int'(slot_byte_idx(wr_off))) +: 8] <= in_byte;
            cnt_q <= wr_cnt + CNT_W'(1);
            if (wr_off == 4'(SLOT_BYTES - 1)) begin
                off_q  <= '0;
                slot_q <= wr_slot + SLOT_W'(1);
            end else begin
                off_q  <= wr_off + 4'd1;
                slot_q <= wr_slot;
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) commit_q <= 1'b0;
        else        commit_q <= commit_d;
    end

    assign commit_o = commit_q;
    assign image_o  = shadow_q;

endmodule

// File: rtl/daf_addr_table.sv
module daf_addr_table
    import daf_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  mac_t [NUM_ENTRIES-1:0] image_i,
    input  mac_t                   probe_i,
    output logic [NUM_ENTRIES-1:0] hit_o
);

    mac_t [NUM_ENTRIES-1:0] entry_q;
    logic [NUM_ENTRIES-1:0] used_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q <= '0;
            used_q  <= '0;
        end else if (load_i) begin
            entry_q <= image_i;
            used_q  <= '1;
        end
    end

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign hit_o[g] = used_q[g] && (entry_q[g] == probe_i);
    end

endmodule

// File: rtl/daf_decide.sv
module daf_decide
    import daf_pkg::*;
#(
    parameter int LEN_W   = 13,
    parameter int MIN_LEN = 14,
    parameter int MAX_LEN = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  mac_t             addr_i,
    input  logic [LEN_W-1:0] len_i,
    input  mode_t            mode_i,
    input  logic             hit_i,
    output logic             valid_o,
    output logic             accept_o,
    output logic             ff_o,
    output logic             mf_o
);

    logic len_ok, bcast, mcast;
    logic acc_d, ff_d, mf_d;

    assign len_ok = (len_i >= LEN_W'(MIN_LEN)) && (len_i <= LEN_W'(MAX_LEN));
    assign bcast  = &addr_i;
    assign mcast  = addr_i[40];

    always_comb begin
        acc_d = 1'b0;
        ff_d  = 1'b0;
        mf_d  = 1'b0;
        if (!len_ok) begin
            acc_d = 1'b0;
        end else if (bcast) begin
            acc_d = 1'b1;
        end else if (mode_i.promisc || mode_i.rx_all) begin
            acc_d = 1'b1;
            ff_d  = 1'b1;
        end else if (mode_i.all_multi && mcast) begin
            acc_d = 1'b1;
            mf_d  = 1'b1;
        end else begin
            acc_d = hit_i ^ mode_i.inverse;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o  <= 1'b0;
            accept_o <= 1'b0;
            ff_o     <= 1'b0;
            mf_o     <= 1'b0;
        end else begin
            valid_o  <= req_i;
            accept_o <= req_i && acc_d;
            ff_o     <= req_i && ff_d;
            mf_o     <= req_i && mf_d;
        end
    end

endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import daf_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int SLOT_BYTES  = 12,
    parameter int MIN_LEN     = 14,
    parameter int MAX_LEN     = 2048,
    parameter int LEN_W       = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             setup_valid,
    input  logic [7:0]       setup_byte,
    input  logic             setup_first,
    input  logic             setup_last,
    input  logic             lookup_valid,
    input  logic [47:0]      lookup_addr,
    input  logic [LEN_W-1:0] lookup_len,
    input  logic             mode_promisc,
    input  logic             mode_rx_all,
    input  logic             mode_all_multi,
    input  logic             mode_inverse,
    output logic             dec_valid,
    output logic             dec_accept,
    output logic             dec_filter_fail,
    output logic             dec_multicast
);

    logic                   commit;
    mac_t [NUM_ENTRIES-1:0] image;
    logic [NUM_ENTRIES-1:0] hits;
    mode_t                  mode;

    assign mode = '{promisc: mode_promisc, rx_all: mode_rx_all,
                    all_multi: mode_all_multi, inverse: mode_inverse};

    daf_setup_loader #(
        .NUM_ENTRIES(NUM_ENTRIES),
        .SLOT_BYTES (SLOT_BYTES)
    ) u_loader (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(setup_valid),
        .in_byte (setup_byte),
        .in_first(setup_first),
        .in_last (setup_last),
        .commit_o(commit),
        .image_o (image)
    );

    daf_addr_table #(
        .NUM_ENTRIES(NUM_ENTRIES)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (commit),
        .image_i(image),
        .probe_i(lookup_addr),
        .hit_o  (hits)
    );

    daf_decide #(
        .LEN_W  (LEN_W),
        .MIN_LEN(MIN_LEN),
        .MAX_LEN(MAX_LEN)
    ) u_decide (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (lookup_valid),
        .addr_i  (lookup_addr),
        .len_i   (lookup_len),
        .mode_i  (mode),
        .hit_i   (|hits),
        .valid_o (dec_valid),
        .accept_o(dec_accept),
        .ff_o    (dec_filter_fail),
        .mf_o    (dec_multicast)
    );

endmodule

// File: rtl/daf_checker.sv
module daf_checker #(
    parameter int MIN_LEN = 14,
    parameter int MAX_LEN = 2048,
    parameter int LEN_W   = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lookup_valid,
    input logic [47:0]      lookup_addr,
    input logic [LEN_W-1:0] lookup_len,
    input logic             mode_promisc,
    input logic             mode_rx_all,
    input logic             mode_all_multi,
    input logic             dec_valid,
    input logic             dec_accept,
    input logic             dec_filter_fail,
    input logic             dec_multicast
);

    logic len_ok;
    assign len_ok = (lookup_len >= LEN_W'(MIN_LEN)) && (lookup_len <= LEN_W'(MAX_LEN));

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> dec_valid);

    a_r10_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid |=> !dec_valid);

    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !dec_accept && !dec_filter_fail && !dec_multicast);

    a_r9_length_reject: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid && !len_ok |=> !dec_accept && !dec_filter_fail && !dec_multicast);

    a_r2_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid && len_ok && (&lookup_addr)
        |=> dec_accept && !dec_filter_fail && !dec_multicast);

    a_r3_promisc: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid && len_ok && !(&lookup_addr) && (mode_promisc || mode_rx_all)
        |=> dec_accept && dec_filter_fail && !dec_multicast);

    a_r4_multicast: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid && len_ok && !(&lookup_addr) && !mode_promisc && !mode_rx_all &&
        mode_all_multi && lookup_addr[40]
        |=> dec_accept && dec_multicast && !dec_filter_fail);

    a_r4_flags_imply_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_filter_fail || dec_multicast) |-> dec_accept &&
        ($countones({dec_filter_fail, dec_multicast}) == 1));

endmodule

bind dst_addr_filter daf_checker #(
    .MIN_LEN(MIN_LEN),
    .MAX_LEN(MAX_LEN),
    .LEN_W  (LEN_W)
) u_daf_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .lookup_valid   (lookup_valid),
    .lookup_addr    (lookup_addr),
    .lookup_len     (lookup_len),
    .mode_promisc   (mode_promisc),
    .mode_rx_all    (mode_rx_all),
    .mode_all_multi (mode_all_multi),
    .dec_valid      (dec_valid),
    .dec_accept     (dec_accept),
    .dec_filter_fail(dec_filter_fail),
    .dec_multicast  (dec_multicast)
);

// File: tb/test_dst_addr_filter.sv
`timescale 1ns/1ps
module test_dst_addr_filter;

    localparam int LEN_W = 13;
    localparam int NV    = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             setup_valid = 1'b0;
    logic [7:0]       setup_byte = '0;
    logic             setup_first = 1'b0;
    logic             setup_last = 1'b0;
    logic             lookup_valid = 1'b0;
    logic [47:0]      lookup_addr = '0;
    logic [LEN_W-1:0] lookup_len = '0;
    logic             mode_promisc = 1'b0;
    logic             mode_rx_all = 1'b0;
    logic             mode_all_multi = 1'b0;
    logic             mode_inverse = 1'b0;
    logic             dec_valid, dec_accept, dec_filter_fail, dec_multicast;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dst_addr_filter i_dst_addr_filter (.*);

    // {addr, len, modes{promisc,rx_all,all_multi,inverse}, exp{acc,ff,mf}}
    localparam logic [67:0] VEC [NV] = '{
        {48'h02A1_2233_4405, 13'd64,   4'b0000, 3'b100},  // R5 hit
        {48'h02A1_2233_4499, 13'd64,   4'b0000, 3'b000},  // R5 miss
        {48'hFFFF_FFFF_FFFF, 13'd64,   4'b0001, 3'b100},  // R2 broadcast under inverse
        {48'h02A1_2233_4499, 13'd64,   4'b1000, 3'b110},  // R3 promiscuous
        {48'h02A1_2233_4499, 13'd64,   4'b0100, 3'b110},  // R3 receive-all
        {48'h0100_5E00_0001, 13'd64,   4'b0010, 3'b101},  // R4 multicast pass
        {48'h0100_5E00_0001, 13'd64,   4'b1010, 3'b110},  // R4 below R3 in precedence
        {48'h0100_5E00_0001, 13'd64,   4'b0000, 3'b000},  // R4 mode off
        {48'h02A1_2233_4405, 13'd64,   4'b0001, 3'b000},  // R6 inverted hit
        {48'h02A1_2233_4499, 13'd64,   4'b0001, 3'b100},  // R6 inverted miss
        {48'h02A1_2233_440F, 13'd14,   4'b0000, 3'b100},  // R7 last slot, R9 min length
        {48'h02A1_2233_4400, 13'd2048, 4'b0000, 3'b100},  // R7 first slot, R9 max length
        {48'h02A1_2233_4400, 13'd13,   4'b0000, 3'b000},  // R9 runt
        {48'hFFFF_FFFF_FFFF, 13'd2049, 4'b0000, 3'b000},  // R9 oversize broadcast
        {48'h02A1_2233_4499, 13'd10,   4'b1000, 3'b000},  // R9 runt in promiscuous
        {48'h0100_5E00_0001, 13'd64,   4'b0001, 3'b100}   // R6 multicast via inverse only
    };
    localparam int VTAG [NV] = '{5,5,2,3,3,4,4,4,6,6,7,7,9,9,9,6};

    function automatic logic [47:0] mac_of(input logic [7:0] seed, input int n);
        return {8'h02, seed, 8'h22, 8'h33, 8'h44, 8'(n)};
    endfunction

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b (valid,acc,ff,mf)", req, act, exp);
        end
    endtask

    task automatic send_setup(input int nbytes, input logic [7:0] seed);
        for (int i = 0; i < nbytes; i++) begin
            int slot = i / 12;
            int off  = i % 12;
            logic [47:0] m = mac_of(seed, slot);
            int k = (off / 4) * 2 + (off % 2);
            @(negedge clk);
            setup_valid = 1'b1;
            setup_first = (i == 0);
            setup_last  = (i == nbytes - 1);
            if ((off % 4) < 2 && slot < 16) setup_byte = m[8*(5-k) +: 8];
            else                            setup_byte = 8'hEE;
        end
        @(negedge clk);
        setup_valid = 1'b0;
        setup_first = 1'b0;
        setup_last  = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic lookup(input logic [47:0] a, input logic [LEN_W-1:0] l,
                          input logic [3:0] md, output logic [3:0] res);
        @(negedge clk);
        lookup_valid = 1'b1;
        lookup_addr  = a;
        lookup_len   = l;
        {mode_promisc, mode_rx_all, mode_all_multi, mode_inverse} = md;
        @(negedge clk);
        lookup_valid = 1'b0;
        res = {dec_valid, dec_accept, dec_filter_fail, dec_multicast};
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of outputs
        chk("R1 reset outputs", {dec_valid, dec_accept, dec_filter_fail, dec_multicast}, 4'b0000);
        // R1: empty table, zero address does not match
        lookup(48'h0, 13'd64, 4'b0000, r);
        chk("R1 zero addr empty table", r, 4'b1000);
        lookup(mac_of(8'hA1, 3), 13'd64, 4'b0000, r);
        chk("R1 no entry before load", r, 4'b1000);
        // R10: valid drops the cycle after
        @(negedge clk);
        chk("R10 single-cycle valid", {dec_valid, dec_accept, dec_filter_fail, dec_multicast}, 4'b0000);

        send_setup(192, 8'hA1);
        for (int v = 0; v < NV; v++) begin
            lookup(VEC[v][67:20], VEC[v][19:7], VEC[v][6:3], r);
            chk($sformatf("R%0d vector %0d", VTAG[v], v), r, {1'b1, VEC[v][2:0]});
        end

        // R8: short frame leaves table unchanged
        send_setup(191, 8'hB2);
        lookup(mac_of(8'hB2, 3), 13'd64, 4'b0000, r);
        chk("R8 short frame not loaded", r, 4'b1000);
        lookup(mac_of(8'hA1, 3), 13'd64, 4'b0000, r);
        chk("R8 old table kept after short", r, 4'b1100);
        // R8: long frame leaves table unchanged
        send_setup(193, 8'hC3);
        lookup(mac_of(8'hC3, 7), 13'd64, 4'b0000, r);
        chk("R8 long frame not loaded", r, 4'b1000);
        lookup(mac_of(8'hA1, 7), 13'd64, 4'b0000, r);
        chk("R8 old table kept after long", r, 4'b1100);
        // R8: exact frame replaces table
        send_setup(192, 8'hD4);
        lookup(mac_of(8'hD4, 9), 13'd64, 4'b0000, r);
        chk("R8 new table loaded", r, 4'b1100);
        lookup(mac_of(8'hA1, 9), 13'd64, 4'b0000, r);
        chk("R8 old entry replaced", r, 4'b1000);
        // R7: filler byte position must not be used as address
        lookup({8'h02, 8'hEE, 8'h22, 8'h33, 8'h44, 8'h09}, 13'd64, 4'b0000, r);
        chk("R7 filler ignored", r, 4'b1000);
        @(negedge clk);
        chk("R10 idle after lookup", {dec_valid, dec_accept, dec_filter_fail, dec_multicast}, 4'b0000);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule